// File: doc/BRIEF.md
# Switching Clock Source Selector

This block produces the per-cycle switching strobe for a DC-DC converter controller. One input pin chooses the clock source, and the choice depends only on what that pin does. If the pin is held low, the strobe repeats at a fixed interval that software programs as a count of system-clock cycles. If the pin is held high, the interval is swept along a triangle around that nominal count. If the pin carries an external clock whose rate falls in an accepted window, the strobe follows that clock.

The pin first passes through a two-flop synchronizer. Each synchronized rising edge closes an interval measurement, which is then compared against the programmed nominal. The block locks to the external clock after a run of consecutive good intervals. It drops back to its own counter when the pin goes quiet for two nominal periods. After that fallback, the level the pin has settled at decides whether the internal rate is fixed or swept. All pins are plain control and status signals. No data flows through the block, so it has no handshake.

Top module: `swclk_selector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `sw_pulse` is 0, `mode` is 0 and `ext_lock` is 0.
- R2: With `sync_in` steadily low, `mode` is 0 (fixed) and `sw_pulse` is a one-cycle strobe that repeats exactly every `nom_period` cycles. A change of `nom_period` applies from the next interval on.
- R3: With `sync_in` steadily high, `mode` is 1 (swept). Each strobe interval equals `nom_period` plus an offset. The offset is updated once per interval and follows a triangle with a full sweep of `MOD_CYCLES` system cycles. The offset magnitude never exceeds floor(`nom_period`*`SPREAD_PCT`/100).
- R4: An external clock is accepted when `LOCK_EDGES` consecutive rising-to-rising intervals p each satisfy 3p >= 2*`nom_period` and 6p <= 5*`nom_period`, and each high and low phase lasts at least `MIN_PHASE` cycles. `ext_lock` then rises and `mode` becomes 2 (external).
- R5: While locked, exactly one strobe is issued per rising edge of `sync_in`. Strobe spacing equals the external period, with no sweep applied.
- R6: Intervals outside the window of R4 are never accepted. With a nominal of 200, the periods 133 and 168 stay unlocked, and 134 and 166 lock.
- R7: A clock whose period lies in the window but has a phase shorter than `MIN_PHASE` cycles is never accepted.
- R8: When no edge reaches the synchronized `sync_in` for 2*`nom_period` cycles, `ext_lock` falls and the internal counter resumes. `mode` then returns to 1 if the pin rests high or 0 if it rests low.
- R9: A level change on `sync_in` reaches `mode` on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Asynchronous source-select pin: level or external clock |
| nom_period | input | PER_W | Nominal switching period in system cycles (at least 4) |
| sw_pulse | output | 1 | One-cycle switching strobe |
| mode | output | 2 | 0 fixed, 1 swept, 2 external |
| ext_lock | output | 1 | External clock accepted and present |

## Verification
A pin change takes two synchronizer cycles to become visible and one more register to reach `mode`. A driven external rising edge therefore yields its strobe three cycles later, and the bench samples `mode` two and three edges after a level change to pin that boundary. The loss of the external clock is registered 2*`nom_period`+2 edges after the last driven edge, so the bench checks `ext_lock` a few cycles before and after that point. Strobe spacing is measured between successive strobes, with every sample taken on the falling clock edge. This keeps each result independent of the exact edge on which it was issued.

// File: rtl/swsel_pkg.sv
package swsel_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_SPREAD = 2'd1,
    MODE_EXT    = 2'd2
  } sw_mode_e;
endpackage

// File: rtl/swsel_sync_edge.sv
module swsel_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // stage k captures stage k-1; the extra last stage holds the previous level
  logic [STAGES:0] chain;

  for (genvar k = 0; k <= STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[k] <= 1'b0;
        else        chain[k] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[k] <= 1'b0;
        else        chain[k] <= chain[k-1];
      end
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/swsel_ext_detect.sv
module swsel_ext_detect #(
  parameter int PER_W      = 16,
  parameter int MIN_PHASE  = 38,
  parameter int LOCK_EDGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [PER_W-1:0] nom,
  output logic             present
);
  localparam int CW = PER_W + 2;
  localparam int XW = CW + 3;
  localparam int GW = $clog2(LOCK_EDGES + 1);
  localparam logic [CW-1:0] ONE_C  = CW'(1);
  localparam logic [CW-1:0] MAX_C  = '1;
  localparam logic [CW-1:0] MINP_C = CW'(MIN_PHASE);
  localparam logic [GW-1:0] LAST_G = GW'(LOCK_EDGES - 1);
  localparam logic [GW-1:0] ONE_G  = GW'(1);

  logic [CW-1:0] r_cnt;     // cycles since last rising edge, 0 = none yet
  logic [CW-1:0] e_cnt;     // cycles since last edge of either polarity
  logic          phase_ok;  // high phase of the current interval was long enough
  logic [GW-1:0] good_cnt;
  logic          edge_any, cur_ph_ok, per_ok, good, timeout;
  logic [CW-1:0] tmo;
  logic [XW-1:0] p_x, n_x;

  assign edge_any  = rise | fall;
  assign tmo       = {1'b0, nom, 1'b0};
  assign timeout   = (e_cnt >= tmo);
  assign cur_ph_ok = (e_cnt >= MINP_C) && (e_cnt != '0);
  assign p_x       = {3'b000, r_cnt};
  assign n_x       = {5'b00000, nom};
  // 1.2x..1.5x the nominal rate: 2*nom <= 3*p and 6*p <= 5*nom
  assign per_ok    = (r_cnt != '0) &&
                     (((p_x << 1) + p_x) >= (n_x << 1)) &&
                     (((p_x << 2) + (p_x << 1)) <= ((n_x << 2) + n_x));
  assign good      = rise && per_ok && phase_ok && cur_ph_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_cnt    <= '0;
      e_cnt    <= '0;
      phase_ok <= 1'b0;
    end else begin
      if (rise)                                r_cnt <= ONE_C;
      else if (r_cnt != '0 && r_cnt != MAX_C)  r_cnt <= r_cnt + ONE_C;
      if (edge_any)                            e_cnt <= ONE_C;
      else if (e_cnt != '0 && e_cnt != MAX_C)  e_cnt <= e_cnt + ONE_C;
      if (rise)      phase_ok <= 1'b1;
      else if (fall) phase_ok <= phase_ok & cur_ph_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present  <= 1'b0;
      good_cnt <= '0;
    end else if (present) begin
      if (timeout && !edge_any) begin
        present  <= 1'b0;
        good_cnt <= '0;
      end
    end else if (rise) begin
      if (!good)                    good_cnt <= '0;
      else if (good_cnt == LAST_G) begin
        present  <= 1'b1;
        good_cnt <= '0;
      end else                      good_cnt <= good_cnt + ONE_G;
    end else if (timeout) begin
      good_cnt <= '0;
    end
  end

  assert_lock_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(rise));
  assert_loss_after_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |-> $past(e_cnt >= tmo));
endmodule

// File: rtl/swsel_dither.sv
module swsel_dither #(
  parameter int PER_W      = 16,
  parameter int MOD_CYCLES = 250000,
  parameter int SPREAD_PCT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    enable,
  input  logic [PER_W-1:0]        nom,
  output logic signed [PER_W:0]   offset
);
  localparam int PH_W = $clog2(MOD_CYCLES);
  localparam int QTR  = MOD_CYCLES / 4;
  localparam int PW   = PH_W + PER_W;
  localparam int AW   = PER_W + 7;
  localparam logic [PH_W-1:0] Q1    = PH_W'(QTR);
  localparam logic [PH_W-1:0] Q2    = PH_W'(2 * QTR);
  localparam logic [PH_W-1:0] Q3    = PH_W'(3 * QTR);
  localparam logic [PH_W-1:0] PLAST = PH_W'(MOD_CYCLES - 1);
  localparam logic [PH_W-1:0] ONE_P = PH_W'(1);

  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  mag_raw, mag;
  logic             neg;
  logic [PER_W-1:0] amp, scaled, off_mag;

  always_ff @(posedge clk) begin
    if (!rst_n)            ph <= '0;
    else if (ph == PLAST)  ph <= '0;
    else                   ph <= ph + ONE_P;
  end

  // triangle: -QTR at 0, rising to +QTR at half sweep, back down
  always_comb begin
    if (ph < Q1)      begin mag_raw = Q1 - ph; neg = 1'b1; end
    else if (ph < Q2) begin mag_raw = ph - Q1; neg = 1'b0; end
    else if (ph < Q3) begin mag_raw = Q3 - ph; neg = 1'b0; end
    else              begin mag_raw = ph - Q3; neg = 1'b1; end
    mag = (mag_raw > Q1) ? Q1 : mag_raw;
  end

  assign amp    = PER_W'(({7'b0, nom} * AW'(SPREAD_PCT)) / AW'(100));
  assign scaled = PER_W'(({{PER_W{1'b0}}, mag} * {{PH_W{1'b0}}, amp}) / PW'(QTR));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) offset <= '0;
    else if (step)         offset <= neg ? -$signed({1'b0, scaled}) : $signed({1'b0, scaled});
  end

  assign off_mag = offset[PER_W] ? PER_W'(-offset) : offset[PER_W-1:0];

  assert_dither_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && enable) |=> (off_mag <= $past(amp)));
  assert_fixed_no_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (offset == '0));
endmodule

// File: rtl/swclk_selector.sv
module swclk_selector
  import swsel_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 38,
  parameter int LOCK_EDGES  = 2,
  parameter int MOD_CYCLES  = 250000,
  parameter int SPREAD_PCT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [PER_W-1:0] nom_period,
  output logic             sw_pulse,
  output logic [1:0]       mode,
  output logic             ext_lock
);
  localparam int TW = PER_W + 2;
  localparam logic [TW-1:0] ONE_T = TW'(1);

  logic                  lvl, rise, fall, present;
  logic signed [PER_W:0] offset;
  logic signed [TW-1:0]  off_x, tgt_s;
  logic [TW-1:0]         tgt, cnt;
  logic                  wrap, dith_en, pulse_d;
  sw_mode_e              mode_q;

  swsel_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  swsel_ext_detect #(.PER_W(PER_W), .MIN_PHASE(MIN_PHASE), .LOCK_EDGES(LOCK_EDGES)) u_det (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .nom(nom_period), .present(present)
  );

  assign dith_en = lvl & ~present;

  swsel_dither #(.PER_W(PER_W), .MOD_CYCLES(MOD_CYCLES), .SPREAD_PCT(SPREAD_PCT)) u_dith (
    .clk(clk), .rst_n(rst_n), .step(wrap & ~present), .enable(dith_en),
    .nom(nom_period), .offset(offset)
  );

  assign off_x = TW'(offset);
  assign tgt_s = $signed({2'b00, nom_period}) + off_x;
  assign tgt   = $unsigned(tgt_s);
  assign wrap  = (cnt + ONE_T) >= tgt;

  always_ff @(posedge clk) begin
    if (!rst_n || present) cnt <= '0;
    else if (wrap)         cnt <= '0;
    else                   cnt <= cnt + ONE_T;
  end

  assign pulse_d = present ? rise : wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_pulse <= 1'b0;
      mode_q   <= MODE_FIXED;
    end else begin
      sw_pulse <= pulse_d;
      mode_q   <= present ? MODE_EXT : (lvl ? MODE_SPREAD : MODE_FIXED);
    end
  end

  assign mode     = mode_q;
  assign ext_lock = present;

  assert_ext_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_lock |=> (mode == MODE_EXT));
  assert_ext_pulse_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pulse && $past(ext_lock)) |-> $past(rise));
endmodule

// File: tb/swclk_selector_bench.sv
module swclk_selector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic [15:0] nom_period = 16'd200;
  logic        sw_pulse, ext_lock;
  logic [1:0]  mode;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  swclk_selector #(.MOD_CYCLES(40000)) u_swclk_selector (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .nom_period(nom_period),
    .sw_pulse(sw_pulse), .mode(mode), .ext_lock(ext_lock)
  );

  // strobe gap statistics, sampled on the falling edge
  int cyc = 0, last_t = 0, np = 0, gmin = 0, gmax = 0, clr_gen = 0, seen_gen = -1;
  always @(negedge clk) begin
    cyc++;
    if (seen_gen != clr_gen) begin
      seen_gen = clr_gen; np = 0; gmin = 1 << 30; gmax = 0;
    end
    if (sw_pulse) begin
      if (np > 0) begin
        if (cyc - last_t < gmin) gmin = cyc - last_t;
        if (cyc - last_t > gmax) gmax = cyc - last_t;
      end
      np++;
      last_t = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic clear_stats();
    @(posedge clk);
    #1 clr_gen++;
  endtask

  task automatic ext_clock(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      repeat (hi) @(negedge clk);
      sync_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  // vector table for nominal 200: high cycles, low cycles, expected lock
  localparam int NV = 8;
  localparam int VH[NV] = '{75, 100, 50, 20, 67, 83, 84, 66};
  localparam int VL[NV] = '{75, 100, 50, 130, 67, 83, 84, 67};
  localparam int VE[NV] = '{1, 0, 0, 0, 1, 1, 0, 0};

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(5);
    check(sw_pulse == 1'b0, "R1 pulse in reset", int'(sw_pulse), 0);
    check(mode == 2'd0, "R1 mode in reset", int'(mode), 0);
    check(ext_lock == 1'b0, "R1 lock in reset", int'(ext_lock), 0);
    to_neg(); rst_n = 1'b1;
    tick(1);
    check(sw_pulse == 1'b0 && ext_lock == 1'b0 && mode == 2'd0, "R1 first cycle", int'(mode), 0);

    // R2: fixed rate at two nominal values
    tick(300); clear_stats(); tick(1000);
    check(np >= 4 && gmin == 200 && gmax == 200, "R2 fixed period 200", gmax, 200);
    check(mode == 2'd0, "R2 mode fixed", int'(mode), 0);
    to_neg(); nom_period = 16'd300;
    tick(400); clear_stats(); tick(1300);
    check(np >= 4 && gmin == 300 && gmax == 300, "R2 fixed period 300", gmin, 300);

    // R9: level reaches mode on the third edge
    to_neg(); sync_in = 1'b1;
    tick(2);
    check(mode == 2'd0, "R9 mode after two edges", int'(mode), 0);
    tick(1);
    check(mode == 2'd1, "R9 mode after three edges", int'(mode), 1);

    // R3: swept rate, nominal 1000, offset within +-30
    to_neg(); nom_period = 16'd1000;
    tick(2000); clear_stats(); tick(50000);
    check(mode == 2'd1, "R3 mode swept", int'(mode), 1);
    check(gmax <= 1030, "R3 upper clamp", gmax, 1030);
    check(gmin >= 970, "R3 lower clamp", gmin, 970);
    check(gmax >= 1020, "R3 sweep reaches top", gmax, 1020);
    check(gmin <= 980, "R3 sweep reaches bottom", gmin, 980);

    // table walk: R4 R5 R6 R7 R8
    to_neg(); sync_in = 1'b0; nom_period = 16'd200;
    tick(1000);
    for (int v = 0; v < NV; v++) begin
      to_neg();
      ext_clock(VH[v], VL[v], 6);
      if (VE[v] == 1) begin
        check(ext_lock == 1'b1, "R4 R6 lock accepted", int'(ext_lock), 1);
        check(mode == 2'd2, "R4 mode external", int'(mode), 2);
        clear_stats(); to_neg();
        ext_clock(VH[v], VL[v], 4);
        check(np >= 3 && gmin == VH[v] + VL[v] && gmax == VH[v] + VL[v],
              "R5 strobe follows sync", gmax, VH[v] + VL[v]);
      end else if (VH[v] < 38) begin
        check(ext_lock == 1'b0, "R7 short phase rejected", int'(ext_lock), 0);
      end else begin
        check(ext_lock == 1'b0, "R6 period out of window", int'(ext_lock), 0);
        check(mode != 2'd2, "R6 mode not external", int'(mode), 0);
      end
      repeat (2 * 200 + 20) @(negedge clk);
      check(ext_lock == 1'b0, "R8 released after quiet low", int'(ext_lock), 0);
      check(mode == 2'd0, "R8 mode fixed after low", int'(mode), 0);
    end

    // R8: loss boundary with pin resting high
    to_neg();
    ext_clock(75, 75, 5);
    check(ext_lock == 1'b1, "R4 lock before loss test", int'(ext_lock), 1);
    sync_in = 1'b1;
    tick(400);
    check(ext_lock == 1'b1, "R8 held before timeout", int'(ext_lock), 1);
    tick(5);
    check(ext_lock == 1'b0, "R8 lost after timeout", int'(ext_lock), 0);
    check(mode == 2'd1, "R8 mode swept after high", int'(mode), 1);
    clear_stats(); tick(1300);
    check(np >= 5 && gmin >= 194 && gmax <= 206, "R8 internal rate resumes", gmax, 200);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule